// File: doc/BRIEF.md
# Crystal Clock Frequency Window Monitor

This block watches an external crystal clock from a reference clock domain. The crystal's activity arrives as a single-cycle pulse per monitored edge, already synchronized to the reference clock. Two independent detectors run on that pulse stream. A stop detector declares a failure when no pulse has arrived for a set number of reference cycles. A frequency detector counts pulses over a fixed window of reference cycles and declares a failure when the count falls outside a software-programmed band.

Each detector has its own enable, a sticky flag and an interrupt enable. A small register port, with a 2-bit address and 10-bit data, holds the control bits and the two 10-bit band limits, and gives write-one-to-clear access to the flags. The interrupt line is driven by each flag gated with its own interrupt enable.

Top module: `xclk_watch`

## Requirements
- R1: After reset, both flags and `irq` are 0, the control word reads 0, the upper limit reads 1023 and the lower limit reads 0.
- R2: Register map. Address 0 is control: bit 0 stop enable, bit 1 stop interrupt enable, bit 2 frequency enable, bit 3 frequency interrupt enable. Address 1 is status: bit 0 stop flag, bit 8 frequency flag. Address 2 is the upper limit and address 3 is the lower limit, each in bits 9:0. Every address reads back over `bus_rdata` with no wait state.
- R3: With the stop detector enabled, the stop flag sets on the STOP_CYCLES-th reference cycle after the last cycle that carried a monitored pulse, and not earlier.
- R4: With the stop detector disabled, the stop flag never sets, however long the pulses are absent.
- R5: With the frequency detector enabled, pulses are counted over windows of WIN_CYCLES reference cycles. A window count greater than the upper limit sets the frequency flag.
- R6: A window count smaller than the lower limit sets the frequency flag. A count equal to either limit does not set it.
- R7: The window count saturates at 1023 and does not wrap.
- R8: With the frequency detector disabled, the frequency flag never sets.
- R9: Writing 1 to a status bit clears that flag. Writing 0 to a status bit leaves that flag unchanged.
- R10: When a set event and a clearing write fall in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when some flag is set and the interrupt enable of that same flag is also set.
- R12: A flag stays set after its fault condition ends, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_edge | input | 1 | One-cycle pulse per monitored clock edge, synchronized to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 10 | Register write data |
| bus_rdata | output | 10 | Register read data for bus_addr |
| stop_flag | output | 1 | Sticky clock-stop flag |
| freq_flag | output | 1 | Sticky frequency-out-of-band flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sets WIN_CYCLES to 1100 and STOP_CYCLES to 16. A window of 1100 cycles is longer than the 1023 count ceiling, so a pulse on every cycle pushes the count into saturation, where a wrapping counter would read a small value instead. The value 1100 also divides exactly by the pulse periods 1, 2 and 4, so every window holds a known count, and the equality cases at each limit can be checked exactly. The short stop threshold lets the bench pin the stop flag to its exact cycle and make a clearing write land in that same cycle.

// File: rtl/xclk_watch.sv
module xclk_watch #(
  parameter int WIN_CYCLES  = 1024,
  parameter int STOP_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mon_edge,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [9:0] bus_wdata,
  output logic [9:0] bus_rdata,
  output logic       stop_flag,
  output logic       freq_flag,
  output logic       irq
);
  localparam int BW     = 10;
  localparam logic [BW-1:0] CMAX = '1;
  localparam int WIN_W  = $clog2(WIN_CYCLES);
  localparam int STOP_W = $clog2(STOP_CYCLES + 1);
  localparam logic [1:0] A_CTL = 2'd0, A_STS = 2'd1, A_UP = 2'd2, A_LO = 2'd3;

  logic [3:0]        ctl;
  logic [BW-1:0]     upper, lower, edge_cnt, cnt_nx;
  logic [WIN_W-1:0]  win_cnt;
  logic [STOP_W-1:0] idle;
  logic              win_last, freq_set, stop_set, sts_wr;

  wire stop_en = ctl[0];
  wire stop_ie = ctl[1];
  wire freq_en = ctl[2];
  wire freq_ie = ctl[3];

  assign sts_wr   = bus_wr && bus_addr == A_STS;
  assign cnt_nx   = (mon_edge && edge_cnt != CMAX) ? edge_cnt + 1'b1 : edge_cnt;
  assign win_last = win_cnt == WIN_W'(WIN_CYCLES - 1);
  assign freq_set = freq_en && win_last && (cnt_nx > upper || cnt_nx < lower);
  assign stop_set = stop_en && !mon_edge && idle == STOP_W'(STOP_CYCLES - 1);
  assign irq      = (stop_flag && stop_ie) || (freq_flag && freq_ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      upper <= CMAX;
      lower <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTL:   ctl   <= bus_wdata[3:0];
        A_UP:    upper <= bus_wdata;
        A_LO:    lower <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
    end else if (!freq_en || win_last) begin
      win_cnt  <= '0;
      edge_cnt <= '0;
    end else begin
      win_cnt  <= win_cnt + 1'b1;
      edge_cnt <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               idle <= '0;
    else if (!stop_en || mon_edge)            idle <= '0;
    else if (idle != STOP_W'(STOP_CYCLES))    idle <= idle + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_flag <= 1'b0;
      freq_flag <= 1'b0;
    end else begin
      stop_flag <= stop_set || (stop_flag && !(sts_wr && bus_wdata[0]));
      freq_flag <= freq_set || (freq_flag && !(sts_wr && bus_wdata[8]));
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   bus_rdata = {6'd0, ctl};
      A_STS:   bus_rdata = {1'b0, freq_flag, 7'd0, stop_flag};
      A_UP:    bus_rdata = upper;
      default: bus_rdata = lower;
    endcase
  end
endmodule

// File: rtl/xclk_watch_chk.sv
module xclk_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic clr_stop,
  input logic clr_freq,
  input logic stop_en,
  input logic freq_en,
  input logic stop_set,
  input logic freq_set,
  input logic stop_flag,
  input logic freq_flag,
  input logic irq
);
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) stop_flag && !clr_stop |=> stop_flag); // R12
  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) freq_flag && !clr_freq |=> freq_flag); // R12
  AST_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n) !stop_en && !stop_flag |=> !stop_flag); // R4
  AST_FREQ_OFF: assert property (@(posedge clk) disable iff (!rst_n) !freq_en && !freq_flag |=> !freq_flag); // R8
  AST_STOP_CLR: assert property (@(posedge clk) disable iff (!rst_n) clr_stop && !stop_set |=> !stop_flag); // R9
  AST_FREQ_CLR: assert property (@(posedge clk) disable iff (!rst_n) clr_freq && !freq_set |=> !freq_flag); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) stop_set || freq_set |=> stop_flag || freq_flag); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !stop_flag && !freq_flag |-> !irq); // R11
endmodule

bind xclk_watch xclk_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .clr_stop(bus_wr && bus_addr == 2'd1 && bus_wdata[0]),
  .clr_freq(bus_wr && bus_addr == 2'd1 && bus_wdata[8]),
  .stop_en(stop_en), .freq_en(freq_en),
  .stop_set(stop_set), .freq_set(freq_set),
  .stop_flag(stop_flag), .freq_flag(freq_flag), .irq(irq)
);

// File: tb/xclk_watch_bench.sv
module xclk_watch_bench;
  localparam int WIN  = 1100;
  localparam int STOP = 16;

  logic clk = 0, rst_n = 0;
  logic man_edge = 0, gen_edge = 0, mon_edge;
  logic bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [9:0] bus_wdata = 0, bus_rdata;
  logic stop_flag, freq_flag, irq;
  int gen_per = 0, ph = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign mon_edge = man_edge | gen_edge;

  xclk_watch #(.WIN_CYCLES(WIN), .STOP_CYCLES(STOP)) u_xclk_watch (
    .clk(clk), .rst_n(rst_n), .mon_edge(mon_edge), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stop_flag(stop_flag), .freq_flag(freq_flag), .irq(irq));

  always @(negedge clk) begin
    if (gen_per == 0) begin
      gen_edge <= 0; ph <= 0;
    end else begin
      gen_edge <= (ph == 0);
      ph <= (ph + 1 >= gen_per) ? 0 : ph + 1;
    end
  end

  task automatic chk(input logic [9:0] got, input logic [9:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [9:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [9:0] v;
    chk(stop_flag, 0, "R1 stop flag"); chk(freq_flag, 0, "R1 freq flag"); chk(irq, 0, "R1 irq");
    rd(0, v); chk(v, 0, "R1 control");
    rd(2, v); chk(v, 10'h3FF, "R1 upper");
    rd(3, v); chk(v, 0, "R1 lower");
  endtask

  task automatic t_regs;
    logic [9:0] v;
    wr(2, 10'h2A5); rd(2, v); chk(v, 10'h2A5, "R2 upper readback");
    wr(3, 10'h15A); rd(3, v); chk(v, 10'h15A, "R2 lower readback");
    wr(0, 10'h3FA); rd(0, v); chk(v, 10'h00A, "R2 control readback");
    wr(0, 0);
  endtask

  task automatic t_stop;
    logic [9:0] v;
    wr(0, 10'h001);
    @(negedge clk); man_edge = 1; bus_wr = 1; bus_addr = 1; bus_wdata = 10'h001;
    @(negedge clk); man_edge = 0; bus_wr = 0;
    repeat (STOP - 1) @(negedge clk);
    chk(stop_flag, 0, "R3 not yet stopped");
    @(negedge clk);
    chk(stop_flag, 1, "R3 stop flag at threshold");
    rd(1, v); chk(v, 10'h001, "R2 R3 status bit0");
    gen_per = 2; repeat (30) @(negedge clk);
    chk(stop_flag, 1, "R12 stop flag sticky");
    wr(1, 10'h100); chk(stop_flag, 1, "R9 write 0 to bit0 keeps flag");
    wr(1, 10'h001); chk(stop_flag, 0, "R9 clear stop flag");
    repeat (10) @(negedge clk); chk(stop_flag, 0, "R9 stays clear");
    // R10: clearing write lands on the set cycle
    gen_per = 0;
    @(negedge clk); man_edge = 1;
    @(negedge clk); man_edge = 0;
    repeat (STOP - 1) @(negedge clk);
    chk(stop_flag, 0, "R10 before set");
    bus_wr = 1; bus_addr = 1; bus_wdata = 10'h001;
    @(negedge clk); bus_wr = 0;
    chk(stop_flag, 1, "R10 set wins over clear");
  endtask

  task automatic t_stop_off;
    wr(0, 0); wr(1, 10'h001);
    gen_per = 0; repeat (3 * STOP) @(negedge clk);
    chk(stop_flag, 0, "R4 disabled stop detector");
  endtask

  task automatic t_freq(input int per, input logic [9:0] up, input logic [9:0] lo,
                        input logic en, input logic exp, input string req);
    logic [9:0] v;
    wr(0, 0); wr(2, up); wr(3, lo); wr(1, 10'h100);
    gen_per = per;
    wr(0, {7'd0, en, 2'b00});
    repeat (2 * WIN + 10) @(negedge clk);
    chk(freq_flag, exp, req);
    rd(1, v); chk(v[8], exp, req);
  endtask

  task automatic t_irq;
    wr(0, 0); wr(1, 10'h101);
    chk(irq, 0, "R11 no flags");
    t_freq(2, 300, 200, 1, 1, "R11 freq flag ready");
    wr(0, 10'h000); chk(irq, 0, "R11 flag without enable");
    wr(0, 10'h002); chk(irq, 0, "R11 other enable only");
    wr(0, 10'h008); chk(irq, 1, "R11 freq flag and enable");
    wr(1, 10'h100); chk(irq, 0, "R11 after clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_regs;
    t_stop;
    t_stop_off;
    t_freq(4, 300, 200, 1, 0, "R5 count inside band");
    t_freq(2, 300, 200, 1, 1, "R5 count above upper");
    gen_per = 4; repeat (2 * WIN) @(negedge clk);
    chk(freq_flag, 1, "R12 freq flag sticky");
    t_freq(8, 300, 200, 1, 1, "R6 count below lower");
    t_freq(4, 275, 275, 1, 0, "R6 count equal to both limits");
    t_freq(4, 274, 0, 1, 1, "R5 count one above upper");
    t_freq(4, 1023, 276, 1, 1, "R6 count one below lower");
    t_freq(1, 1023, 1023, 1, 0, "R7 saturated count at 1023");
    t_freq(1, 1022, 0, 1, 1, "R7 saturated count above 1022");
    t_freq(2, 300, 200, 0, 0, "R8 disabled freq detector");
    t_irq;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule